// File: doc/BRIEF.md
# Pipelined Burst Read Slave

This block is a memory-mapped read slave whose command phase and data phase are decoupled. A master presents a read command: a start word address and a burst length. The slave takes the command on any clock edge where the read strobe is high and its own wait output is low. Accepted commands wait in a bounded queue. A burst engine drains the queue and walks each burst one word per cycle through a small internal memory. Every word that comes back is marked by a one-cycle data-valid pulse. Several single reads and bursts can be outstanding at once, and their data always returns in the order the commands were accepted.

The wait output only holds off new commands when the queue is full. It never stalls words that are already in flight. A build-time switch selects a fixed-latency variant instead. In that variant every accepted command is a single-word read whose data appears exactly `LATENCY` cycles later, and wait is never raised. A plain write port fills the memory.

The burst engine has two states. `S_IDLE` means no burst is active. The transition `IDLE->STREAM` is taken when the queue holds a command: the engine pops the queue and loads the start address and length. `S_STREAM` issues one memory read per cycle. Its address advances by one word and its remaining count falls by one each cycle. On the last word of a burst the engine takes one of two transitions. `STREAM->STREAM` pops the next queued command in the same cycle, so there is no gap between bursts. `STREAM->IDLE` is taken when the queue is empty.

Top module: `burst_read_slave`

## Requirements
- R1: After reset, `rd_valid` and `cmd_wait` are both low.
- R2: A command is accepted at a rising edge where `cmd_read` is high and `cmd_wait` is low. While `cmd_wait` is high, the master holds the command and nothing is taken.
- R3: The variable-latency variant queues up to `QDEPTH` accepted commands that have not yet started. `cmd_wait` is high only while the queue is full, and the queue never overflows.
- R4: A `cmd_burst` value n from 1 to 2^BCNT_W-1 returns exactly n words. A value of 0 returns exactly one word.
- R5: Word k of a burst (k counting from 0) reads address start+k modulo 2^ADDR_W, so a burst wraps from the top of the memory to address 0.
- R6: Data returns strictly in command-acceptance order, with exactly one `rd_valid` pulse per word. A burst of 4 followed by a burst of 2 yields 6 words in that order.
- R7: Once a burst starts, its words appear on consecutive cycles, whether `cmd_wait` is high or new commands arrive.
- R8: With `FIXED_LAT`=1, a command accepted at edge t has its word on `rd_data` with `rd_valid` high during the cycle after edge t+LATENCY-1. `rd_valid` is low before that, `cmd_burst` is ignored (one word per command), and `cmd_wait` stays low.
- R9: A write with `wr_en` high stores `wr_data` at `wr_addr`, and a later read of that address returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read | input | 1 | Read command strobe |
| cmd_addr | input | ADDR_W | Start word address |
| cmd_burst | input | BCNT_W | Burst length in words (0 means 1) |
| cmd_wait | output | 1 | Command not accepted this cycle |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | `rd_data` holds a valid word this cycle |
| wr_en | input | 1 | Memory fill write strobe |
| wr_addr | input | ADDR_W | Fill write word address |
| wr_data | input | DATA_W | Fill write data |

## Verification
The bound checker checks several properties on every cycle:
- queue occupancy never exceeds its depth, and `cmd_wait` appears only with a full queue;
- each accepted command grows the queue;
- every issued memory read yields a valid pulse on the next cycle, and no valid pulse appears without one;
- within a burst, consecutive issued addresses step by one word with no idle gap.

Only the directed scenarios can show the following:
- the returned data values and their order across mixed bursts;
- address wrap at the top of memory;
- treatment of a zero length;
- the exact cycle of data in the fixed-latency variant;
- that data keeps flowing while `cmd_wait` holds off a command.

// File: rtl/brs_pkg.sv
package brs_pkg;
    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_STREAM = 1'b1
    } brs_state_e;
endpackage

// File: rtl/brs_cmd_fifo.sv
module brs_cmd_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) slots[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/brs_burst_fsm.sv
module brs_burst_fsm
    import brs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [BCNT_W-1:0] head_cnt,
    output logic              q_pop,
    output logic              issue_vld,
    output logic              issue_first,
    output logic [ADDR_W-1:0] issue_addr
);
    brs_state_e        state, state_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [BCNT_W-1:0] remain_q, remain_n;
    logic              first_q, first_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
        end else begin
            state    <= state_n;
            addr_q   <= addr_n;
            remain_q <= remain_n;
            first_q  <= first_n;
        end
    end

    // next state and queue pop
    always_comb begin
        state_n  = state;
        addr_n   = addr_q;
        remain_n = remain_q;
        first_n  = 1'b0;
        q_pop    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (!q_empty) begin
                    q_pop    = 1'b1;
                    addr_n   = head_addr;
                    remain_n = head_cnt;
                    first_n  = 1'b1;
                    state_n  = S_STREAM;
                end
            end
            S_STREAM: begin
                if (remain_q == BCNT_W'(1)) begin
                    if (!q_empty) begin
                        q_pop    = 1'b1;
                        addr_n   = head_addr;
                        remain_n = head_cnt;
                        first_n  = 1'b1;
                        state_n  = S_STREAM;
                    end else begin
                        state_n  = S_IDLE;
                    end
                end else begin
                    addr_n   = addr_q + ADDR_W'(1);
                    remain_n = remain_q - BCNT_W'(1);
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue_vld   = (state == S_STREAM);
        issue_first = first_q;
        issue_addr  = addr_q;
    end
endmodule

// File: rtl/brs_fixed_pipe.sv
module brs_fixed_pipe #(
    parameter int ADDR_W = 6,
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_vld,
    output logic [ADDR_W-1:0] out_addr
);
    logic [STAGES-1:0] vld_sr;
    logic [ADDR_W-1:0] addr_sr [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_sr <= '0;
        end else begin
            vld_sr[0] <= in_vld;
            for (int i = 1; i < STAGES; i++) vld_sr[i] <= vld_sr[i-1];
        end
    end

    always_ff @(posedge clk) begin
        addr_sr[0] <= in_addr;
        for (int i = 1; i < STAGES; i++) addr_sr[i] <= addr_sr[i-1];
    end

    assign out_vld  = vld_sr[STAGES-1];
    assign out_addr = addr_sr[STAGES-1];
endmodule

// File: rtl/brs_mem.sv
module brs_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)  cells[wr_addr] <= wr_data;
        if (rd_req) rd_data <= cells[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_req;
    end
endmodule

// File: rtl/burst_read_slave.sv
module burst_read_slave #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int BCNT_W    = 4,
    parameter int QDEPTH    = 4,
    parameter int FIXED_LAT = 0,
    parameter int LATENCY   = 2,
    localparam int CW       = $clog2(QDEPTH + 1),
    localparam int ENTRY_W  = ADDR_W + BCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BCNT_W-1:0] cmd_burst,
    output logic              cmd_wait,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic              accept;
    logic [BCNT_W-1:0] len_fix;
    logic [CW-1:0]     q_count;
    logic              q_pop;
    logic              issue_vld, issue_first;
    logic [ADDR_W-1:0] issue_addr;

    assign accept  = cmd_read && !cmd_wait;
    assign len_fix = (cmd_burst == '0) ? BCNT_W'(1) : cmd_burst;

    generate
        if (FIXED_LAT != 0) begin : g_fixed
            assign cmd_wait    = 1'b0;
            assign q_count     = '0;
            assign q_pop       = 1'b0;
            assign issue_first = 1'b1;
            brs_fixed_pipe #(.ADDR_W(ADDR_W), .STAGES(LATENCY - 1)) u_pipe (
                .clk(clk), .rst_n(rst_n),
                .in_vld(accept), .in_addr(cmd_addr),
                .out_vld(issue_vld), .out_addr(issue_addr)
            );
        end else begin : g_var
            logic [ENTRY_W-1:0] head;
            logic               q_full, q_empty;
            assign cmd_wait = q_full;
            brs_cmd_fifo #(.WIDTH(ENTRY_W), .DEPTH(QDEPTH)) u_fifo (
                .clk(clk), .rst_n(rst_n),
                .push(accept), .din({cmd_addr, len_fix}),
                .pop(q_pop), .dout(head),
                .full(q_full), .empty(q_empty), .count(q_count)
            );
            brs_burst_fsm #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_fsm (
                .clk(clk), .rst_n(rst_n),
                .q_empty(q_empty),
                .head_addr(head[ENTRY_W-1:BCNT_W]),
                .head_cnt(head[BCNT_W-1:0]),
                .q_pop(q_pop),
                .issue_vld(issue_vld), .issue_first(issue_first),
                .issue_addr(issue_addr)
            );
        end
    endgenerate

    brs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(issue_vld), .rd_addr(issue_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int ADDR_W    = 6,
    parameter int QDEPTH    = 4,
    parameter int FIXED_LAT = 0,
    localparam int CW       = $clog2(QDEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_read,
    input logic              cmd_wait,
    input logic              rd_valid,
    input logic [CW-1:0]     q_count,
    input logic              q_pop,
    input logic              issue_vld,
    input logic              issue_first,
    input logic [ADDR_W-1:0] issue_addr
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(QDEPTH));

    p_wait_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wait |-> (q_count == CW'(QDEPTH)));

    p_accept_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((FIXED_LAT == 0) && cmd_read && !cmd_wait && !q_pop)
            |=> (q_count == $past(q_count) + CW'(1)));

    p_issue_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> rd_valid);

    p_valid_sourced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(issue_vld));

    p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !issue_first) |-> (issue_addr == ADDR_W'($past(issue_addr) + ADDR_W'(1))));

    p_burst_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !issue_first) |-> $past(issue_vld));
endmodule

bind burst_read_slave brs_checker #(
    .ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .FIXED_LAT(FIXED_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_wait(cmd_wait),
    .rd_valid(rd_valid), .q_count(q_count), .q_pop(q_pop),
    .issue_vld(issue_vld), .issue_first(issue_first), .issue_addr(issue_addr)
);

// File: tb/burst_read_slave_tb.sv
module burst_read_slave_tb;
    localparam int AW = 6, DW = 32, BW = 4, QD = 4, LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          rd_v, wt_v, vld_v;
    logic [AW-1:0] ad_v;
    logic [BW-1:0] bc_v;
    logic [DW-1:0] dat_v;
    logic          rd_f, wt_f, vld_f;
    logic [AW-1:0] ad_f;
    logic [BW-1:0] bc_f;
    logic [DW-1:0] dat_f;
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;

    burst_read_slave #(.ADDR_W(AW), .DATA_W(DW), .BCNT_W(BW), .QDEPTH(QD),
                       .FIXED_LAT(0), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_read(rd_v), .cmd_addr(ad_v), .cmd_burst(bc_v),
        .cmd_wait(wt_v), .rd_data(dat_v), .rd_valid(vld_v),
        .wr_en(we), .wr_addr(wa), .wr_data(wd));

    burst_read_slave #(.ADDR_W(AW), .DATA_W(DW), .BCNT_W(BW), .QDEPTH(QD),
                       .FIXED_LAT(1), .LATENCY(LAT)) u_fix (
        .clk(clk), .rst_n(rst_n), .cmd_read(rd_f), .cmd_addr(ad_f), .cmd_burst(bc_f),
        .cmd_wait(wt_f), .rd_data(dat_f), .rd_valid(vld_f),
        .wr_en(we), .wr_addr(wa), .wr_data(wd));

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [DW-1:0] shadow [64];
    logic [DW-1:0] exp_q [256];
    logic          exp_first [256];
    logic [DW-1:0] got_q [256];
    int            got_cyc [256];
    int n_exp = 0, n_got = 0;
    bit saw_wait = 0, saw_flow_in_wait = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && vld_v && n_got < 256) begin
            got_q[n_got]   = dat_v;
            got_cyc[n_got] = cyc;
            n_got++;
        end
        if (rst_n && wt_v) begin
            saw_wait = 1;
            if (vld_v) saw_flow_in_wait = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a);
        return {16'hC0DE, 8'(a), 8'(~a)};
    endfunction

    task automatic fill_mem();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            we = 1; wa = AW'(a); wd = pattern(a); shadow[a] = pattern(a);
        end
        @(negedge clk);
        we = 0;
    endtask

    task automatic issue(input int addr, input int len);
        int words;
        bit took;
        words = (len == 0) ? 1 : len;
        for (int k = 0; k < words; k++) begin
            exp_q[n_exp]     = shadow[(addr + k) % 64];
            exp_first[n_exp] = (k == 0);
            n_exp++;
        end
        rd_v = 1; ad_v = AW'(addr); bc_v = BW'(len);
        took = 0;
        while (!took) begin
            took = !wt_v;
            @(posedge clk);
            @(negedge clk);
        end
        rd_v = 0;
    endtask

    task automatic drain_and_compare(input string req);
        int t = 0;
        while (n_got < n_exp && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        check(n_got == n_exp, req, "word count", DW'(n_got), DW'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_q[i] == exp_q[i], req, $sformatf("word %0d", i), got_q[i], exp_q[i]);
            if (i > 0 && !exp_first[i])
                check(got_cyc[i] == got_cyc[i-1] + 1, "R7", $sformatf("gap before word %0d", i),
                      DW'(got_cyc[i] - got_cyc[i-1]), DW'(1));
        end
        n_exp = 0;
        n_got = 0;
    endtask

    task automatic t_reset();
        check(vld_v == 0 && wt_v == 0, "R1", "variable outputs", {30'd0, vld_v, wt_v}, '0);
        check(vld_f == 0 && wt_f == 0, "R1", "fixed outputs", {30'd0, vld_f, wt_f}, '0);
    endtask

    task automatic t_single();
        issue(5, 1);
        drain_and_compare("R2");
    endtask

    task automatic t_two_bursts();
        issue(8, 4);
        issue(40, 2);
        drain_and_compare("R6");
    endtask

    task automatic t_wrap();
        issue(62, 4);
        drain_and_compare("R5");
    endtask

    task automatic t_zero_len();
        issue(17, 0);
        drain_and_compare("R4");
        issue(20, 15);
        drain_and_compare("R4");
    endtask

    task automatic t_backpressure();
        saw_wait = 0;
        saw_flow_in_wait = 0;
        for (int b = 0; b < 7; b++) issue(b * 8 + 1, 8);
        check(saw_wait, "R3", "wait raised at full queue", DW'(saw_wait), DW'(1));
        check(saw_flow_in_wait, "R7", "data flows while waiting", DW'(saw_flow_in_wait), DW'(1));
        drain_and_compare("R6");
        check(wt_v == 0, "R3", "wait low once drained", DW'(wt_v), '0);
    endtask

    task automatic t_fixed();
        rd_f = 1; ad_f = AW'(33); bc_f = BW'(5);
        @(posedge clk);
        @(negedge clk);
        rd_f = 0;
        check(wt_f == 0, "R8", "fixed wait", DW'(wt_f), '0);
        for (int k = 1; k < LAT; k++) begin
            check(vld_f == 0, "R8", "valid early", DW'(vld_f), '0);
            @(negedge clk);
        end
        check(vld_f == 1, "R8", "valid at latency", DW'(vld_f), DW'(1));
        check(dat_f == shadow[33], "R8", "fixed data", dat_f, shadow[33]);
        @(negedge clk);
        check(vld_f == 0, "R8", "burst length ignored", DW'(vld_f), '0);
    endtask

    task automatic t_write_back();
        @(negedge clk);
        we = 1; wa = AW'(3); wd = 32'h1234_5678; shadow[3] = 32'h1234_5678;
        @(negedge clk);
        we = 0;
        issue(3, 1);
        drain_and_compare("R9");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rd_v = 0; ad_v = '0; bc_v = '0;
        rd_f = 0; ad_f = '0; bc_f = '0;
        we = 0; wa = '0; wd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        fill_mem();
        t_single();
        t_two_bursts();
        t_wrap();
        t_zero_len();
        t_backpressure();
        t_fixed();
        t_write_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule